// File: doc/BRIEF.md
# Four-Core Coherence State Tracker

This block keeps one central table of coherence states for a system with four cores. Each tracked cache line has one two-bit state for every core. The block can take one request per clock. A request is made of a core number, a read-or-write flag and a line address. The block applies the coherence rules to the line named in the request and changes the states of all four cores in a single step. A mode input chooses the rules for each request: the three-state set (Invalid, Shared, Modified) or the four-state set, which adds Exclusive.

One cycle after a request is accepted, the block returns the four-core state vector as it was before the request and as it is after. A line address the table has not seen yet takes a free entry. That entry starts with every core Invalid. When the table has no free entry, the request is flagged as an error and the table is left as it was. The block keeps state only. It does not move data, arbitrate a bus or evict lines.

Top module: `coh_tracker`

## Requirements
- R1: Synchronous active-high reset clears `rsp_valid` and marks every table entry unallocated. After reset, any address is treated as new, so its before vector is all Invalid.
- R2: States are encoded I=00, S=01, E=10, M=11. Core n occupies bits [2n+1:2n] of `rsp_before` and `rsp_after`. An address seen for the first time reports a before vector of 8'h00.
- R3: In three-state mode (`mesi_mode`=0), a read by a core holding Invalid sets that core to Shared. Every other core holding Modified or Exclusive drops to Shared. Other cores holding Shared keep Shared.
- R4: In four-state mode (`mesi_mode`=1), a read by a core holding Invalid, when every other core is Invalid, sets that core to Exclusive.
- R5: In four-state mode, a read by a core holding Invalid, when at least one other core is not Invalid, sets that core to Shared and downgrades every Modified or Exclusive holder to Shared.
- R6: In either mode, a write by a core that is not Modified sets that core to Modified and every other core to Invalid.
- R7: A read by a core that is not Invalid, or a write by a core that is already Modified, leaves the after vector equal to the before vector.
- R8: `req_ready` is always high. A request accepted at edge k gives `rsp_valid`=1 after edge k+1 and no longer. Back-to-back requests to the same line see each other's updates.
- R9: The table holds 16 lines, matched on the full 8-bit address. A request to a new address while all 16 entries are in use returns `rsp_err`=1, with before and after both 8'h00. It allocates nothing and changes no stored state.
- R10: In three-state mode, a request whose before vector holds no Exclusive never produces Exclusive in its after vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mesi_mode | input | 1 | 1 selects four-state rules, 0 selects three-state rules |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_core | input | 2 | Requesting core number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Line address |
| rsp_valid | output | 1 | Response strobe, one cycle per request |
| rsp_err | output | 1 | Table full, request dropped |
| rsp_before | output | 8 | State vector before the request |
| rsp_after | output | 8 | State vector after the request |

## Verification
The bench targets five corner cases. The first is the choice between Exclusive and Shared on a four-state read, which depends on whether other cores hold the line. A design that ignored the other cores would give Exclusive while another copy exists. The second is a mode switch on a line that is already held Exclusive. A wrong design would leave an Exclusive holder in place after a three-state read, or create a new Exclusive copy. The third is back-to-back requests to one line. A design without same-cycle update would report a stale before vector. The fourth is the seventeenth distinct address. A wrong design would overwrite a live entry or allocate past the table, and would then lose that line's states. The fifth is reset. After it, a previously seen address must report all Invalid again.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;
  localparam int CORES = 4;
  localparam int CORE_W = 2;
  localparam int VEC_W = 2 * CORES;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } cstate_e;

  function automatic int count_state(logic [VEC_W-1:0] vec, logic [1:0] st);
    int n;
    n = 0;
    for (int i = 0; i < CORES; i++) begin
      if (vec[2*i +: 2] == st) n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/ctrk_lookup.sv
module ctrk_lookup #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES*ADDR_W-1:0] tags,
  input  logic [LINES-1:0]        used,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx,
  output logic                    has_free,
  output logic [IDX_W-1:0]        free_idx
);
  logic [LINES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = used[g] && (tags[g*ADDR_W +: ADDR_W] == addr);
    end
  endgenerate

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!used[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign has_free = ~&used;

  // R9
  hit_unique_chk: assert final ($onehot0(match));
endmodule

// File: rtl/ctrk_next.sv
module ctrk_next
  import ctrk_pkg::*;
(
  input  logic             mesi,
  input  logic             wr,
  input  logic [CORE_W-1:0] core,
  input  logic [VEC_W-1:0] cur,
  output logic [VEC_W-1:0] nxt
);
  logic [1:0] own;
  logic       others_hold;

  always_comb begin
    own = cur[2*core +: 2];
    others_hold = 1'b0;
    for (int i = 0; i < CORES; i++) begin
      if (i != int'(core) && cur[2*i +: 2] != ST_I) others_hold = 1'b1;
    end
  end

  always_comb begin
    nxt = cur;
    if (wr) begin
      if (own != ST_M) begin
        for (int i = 0; i < CORES; i++) nxt[2*i +: 2] = ST_I;
        nxt[2*core +: 2] = ST_M;
      end
    end else if (own == ST_I) begin
      if (mesi && !others_hold) begin
        nxt[2*core +: 2] = ST_E;
      end else begin
        for (int i = 0; i < CORES; i++) begin
          if (cur[2*i +: 2] == ST_M || cur[2*i +: 2] == ST_E) nxt[2*i +: 2] = ST_S;
        end
        nxt[2*core +: 2] = ST_S;
      end
    end
  end
endmodule

// File: rtl/coh_tracker.sv
module coh_tracker
  import ctrk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mesi_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [VEC_W-1:0]  rsp_before,
  output logic [VEC_W-1:0]  rsp_after
);
  localparam int IDX_W = $clog2(LINES);

  logic [ADDR_W-1:0]       tag_q [LINES];
  logic [VEC_W-1:0]        st_q  [LINES];
  logic [LINES-1:0]        used_q;
  logic [LINES*ADDR_W-1:0] tags_flat;

  logic             hit, has_free, drop, accept;
  logic [IDX_W-1:0] hit_idx, free_idx, sel_idx;
  logic [VEC_W-1:0] cur_vec, nxt_vec;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_flat
      assign tags_flat[g*ADDR_W +: ADDR_W] = tag_q[g];
    end
  endgenerate

  ctrk_lookup #(.ADDR_W(ADDR_W), .LINES(LINES)) u_lookup (
    .tags(tags_flat), .used(used_q), .addr(req_addr),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  assign cur_vec = hit ? st_q[hit_idx] : '0;
  assign sel_idx = hit ? hit_idx : free_idx;
  assign drop    = !hit && !has_free;

  ctrk_next u_next (
    .mesi(mesi_mode), .wr(req_write), .core(req_core), .cur(cur_vec), .nxt(nxt_vec)
  );

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;

  // Entry contents carry no reset, so they can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (accept && !drop) begin
      tag_q[sel_idx] <= req_addr;
      st_q[sel_idx]  <= nxt_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_before <= '0;
      rsp_after  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_err    <= drop;
        rsp_before <= drop ? '0 : cur_vec;
        rsp_after  <= drop ? '0 : nxt_vec;
        if (!drop) used_q[sel_idx] <= 1'b1;
      end
    end
  end

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  // R8
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_before == '0 && rsp_after == '0));
  // R6
  write_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && $past(req_write)) |->
      (count_state(rsp_after, ST_M) == 1 && count_state(rsp_after, ST_I) == CORES - 1));
  // R10
  msi_no_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && !$past(mesi_mode) && count_state(rsp_before, ST_E) == 0)
      |-> count_state(rsp_after, ST_E) == 0);
  // R4
  sole_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (count_state(rsp_after, ST_M) + count_state(rsp_after, ST_E)) != 0)
      |-> count_state(rsp_after, ST_I) == CORES - 1);
endmodule

// File: tb/tb_coh_tracker.sv
module tb_coh_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mesi_mode = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_core = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_before, rsp_after;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_tag [16];
  logic [7:0] m_st  [16];
  logic       m_used [16];

  always #5 clk = ~clk;

  coh_tracker dut (
    .clk(clk), .rst(rst), .mesi_mode(mesi_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_core(req_core), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_before(rsp_before), .rsp_after(rsp_after)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_used[i] = 1'b0; m_tag[i] = '0; m_st[i] = '0;
    end
  endtask

  // Expected result per requirement; returns tag of the rule applied.
  task automatic model_apply(input logic [1:0] c, input logic w, input logic [7:0] a,
                             input logic mm, output logic e_err, output logic [7:0] e_b,
                             output logic [7:0] e_a, output string tag);
    int slot, freeslot;
    logic [1:0] s [4];
    bit others;
    slot = -1; freeslot = -1;
    for (int i = 0; i < 16; i++) begin
      if (m_used[i] && m_tag[i] == a) slot = i;
      if (!m_used[i] && freeslot < 0) freeslot = i;
    end
    if (slot < 0 && freeslot < 0) begin
      e_err = 1'b1; e_b = '0; e_a = '0; tag = "R9"; return;
    end
    e_err = 1'b0;
    e_b = (slot >= 0) ? m_st[slot] : 8'h00;
    for (int i = 0; i < 4; i++) s[i] = e_b[2*i +: 2];
    others = 0;
    for (int i = 0; i < 4; i++) if (i != c && s[i] != 2'b00) others = 1;
    if (w && s[c] != 2'b11) begin
      for (int i = 0; i < 4; i++) s[i] = 2'b00;
      s[c] = 2'b11; tag = "R6";
    end else if (!w && s[c] == 2'b00) begin
      if (mm && !others) begin
        s[c] = 2'b10; tag = "R4";
      end else begin
        for (int i = 0; i < 4; i++) if (s[i] >= 2'b10) s[i] = 2'b01;
        s[c] = 2'b01; tag = mm ? "R5" : "R3";
      end
    end else begin
      tag = "R7";
    end
    e_a = {s[3], s[2], s[1], s[0]};
    if (slot < 0) begin
      slot = freeslot; m_used[slot] = 1'b1; m_tag[slot] = a;
    end
    m_st[slot] = e_a;
  endtask

  // Drive at a falling edge, check the response at the next falling edge.
  task automatic issue(input logic [1:0] c, input logic w, input logic [7:0] a, input logic mm);
    logic e_err;
    logic [7:0] e_b, e_a;
    string tag;
    req_valid = 1'b1; req_core = c; req_write = w; req_addr = a; mesi_mode = mm;
    model_apply(c, w, a, mm, e_err, e_b, e_a, tag);
    @(negedge clk);
    check("R8", rsp_valid, 1, "rsp_valid");
    check(tag, rsp_err, e_err, "rsp_err");
    check(tag, rsp_before, e_b, "rsp_before");
    check(tag, rsp_after, e_a, "rsp_after");
    if (!mm && e_b[1:0] != 2'b10 && e_b[3:2] != 2'b10 && e_b[5:4] != 2'b10 && e_b[7:6] != 2'b10) begin
      checks++;
      if (rsp_after[1:0] == 2'b10 || rsp_after[3:2] == 2'b10 ||
          rsp_after[5:4] == 2'b10 || rsp_after[7:6] == 2'b10) begin
        errors++;
        $display("FAIL R10 exclusive in three-state mode: actual %h expected no 2'b10 field", rsp_after);
      end
    end
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    check("R8", rsp_valid, 0, "rsp_valid after idle");
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1", rsp_valid, 0, "rsp_valid in reset");
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1", rsp_valid, 0, "rsp_valid after reset");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [7:0] pool [6];
    pool[0] = 8'h00; pool[1] = 8'h55; pool[2] = 8'hAA;
    pool[3] = 8'hFF; pool[4] = 8'h3C; pool[5] = 8'h81;
    @(negedge clk);
    check("R1", req_ready, 1, "req_ready");
    do_reset();

    // R2/R4: first read in four-state mode on a fresh line gives Exclusive on core 2
    issue(2'd2, 1'b0, 8'h10, 1'b1);
    // R10/R3: three-state read by core 0 while core 2 is Exclusive
    issue(2'd0, 1'b0, 8'h10, 1'b0);
    // R7: reread by Shared holder
    issue(2'd0, 1'b0, 8'h10, 1'b1);
    // R6 then R7: write, repeated write
    issue(2'd1, 1'b1, 8'h10, 1'b0);
    issue(2'd1, 1'b1, 8'h10, 1'b1);
    // R5: four-state read with a Modified holder
    issue(2'd3, 1'b0, 8'h10, 1'b1);
    // R3: three-state fresh line read
    issue(2'd1, 1'b0, 8'h11, 1'b0);
    idle_check();

    // Near-exhaustive sweep over six lines, all cores, both ops and modes
    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[1:0], lfsr[2], pool[lfsr[7:4] % 6], lfsr[9]);
    end
    idle_check();

    // R9: fill the table (8 lines already used), then overflow
    for (int k = 0; k < 8; k++) issue(2'(k), 1'b0, 8'hC0 + 8'(k), 1'b1);
    issue(2'd0, 1'b1, 8'hEE, 1'b1);
    issue(2'd3, 1'b0, 8'hEF, 1'b0);
    // existing lines unaffected
    issue(2'd1, 1'b0, 8'hC3, 1'b1);
    issue(2'd2, 1'b1, 8'h55, 1'b0);
    idle_check();

    // R1: after reset a known line reads as new
    do_reset();
    issue(2'd0, 1'b0, 8'h55, 1'b0);
    check("R1", rsp_before, 8'h00, "before after reset");
    idle_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule